// File: doc/BRIEF.md
# Dual-Protocol Nibble Host Register Port

This block connects a tone-signalling chip to a host processor over a 4-bit data bus. A static strap input chooses one of two bus styles on the same pins. The first style latches an address and uses separate read and write strobes. The second style uses a host-supplied serial clock, a read/write select line and a single address line. Behind the bus sit four registers. Two can only be written: a tone code for the transmitter and a control word. Two can only be read: the received digit and a status word.

All bus pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are detected on the synchronized copies. The bidirectional bus is modelled as a registered data output plus an output enable. The detector cores are outside this block. They appear as plain input flags.

The status logic masks the fax and call-progress flags through a control bit, and it lets call-progress suppress fax. It keeps a sticky change flag, which clears at the end of a status read or when every detected signal has gone away. A power-down input holds the writable registers cleared and makes the status word report that nothing is detected.

Top module: `tonereg_top`

## Requirements
- R1: With `bus_sel`=1, the address is taken from `din[1:0]` at the falling edge of `ale`. A rising edge of `wr_n` while `cs_n`=0 writes `din` to the tone code at address 00 or to the control word at address 10. Writes to addresses 01 and 11 change nothing.
- R2: With `bus_sel`=1, `bus_oe` is 1 while `rd_n`=0 and `cs_n`=0, and 0 otherwise. Address 11 returns the status word and address 01 returns the received digit.
- R3: With `bus_sel`=0, a falling edge of `rd_n` while `cs_n`=0 and `wr_n`=0 writes `din`. If `ale`=1 the write goes to the control word; if `ale`=0 it goes to the tone code.
- R4: With `bus_sel`=0, `bus_oe` is 1 while `rd_n`=1, `cs_n`=0 and `wr_n`=1. The value of `ale` at the rising edge of `rd_n` selects the status word (1) or the received digit (0).
- R5: While `cs_n`=1, no register is written and `bus_oe` stays 0.
- R6: Control word bit positions are: bit 3 drives `cpt_gen_en`, bit 2 drives `fast_detect`, bit 1 drives `det_out_en`, and bit 0 drives `dtmf_gen_en`. The word holds its value between writes.
- R7: The status word is {bit 3: not `dtmf_present`, bit 2: fax flag, bit 1: call-progress flag, bit 0: change flag}.
- R8: When `det_out_en`=0, the fax and call-progress flags and the `fax_out` and `cpt_out` pins are forced to 0.
- R9: While call progress is detected, the fax flag and `fax_out` are forced to 0.
- R10: The change flag sets when `dtmf_present` rises, when the masked fax flag rises, or when the masked call-progress flag rises.
- R11: The change flag clears when a status read strobe ends. A new set event in the same cycle takes priority over the clear.
- R12: The change flag clears on its own, without a read, once `dtmf_present` is 0 and both masked flags are 0.
- R13: While `pwr_down`=1, the control word and tone code are held at 0 and writes are ignored. The status word reads 1000 and the received digit reads 0.
- R14: The received digit read over the bus equals `dtmf_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Static strap: 1 = address-latch style, 0 = serial-clock style |
| pwr_down | input | 1 | Power-down: clears registers and reports non-detect |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch strobe, or register select line in serial-clock style |
| rd_n | input | 1 | Read strobe, or bus clock in serial-clock style |
| wr_n | input | 1 | Write strobe, or read/write select (1 = read) in serial-clock style |
| din | input | 4 | Data (and address) from the host |
| dout | output | 4 | Data returned to the host |
| bus_oe | output | 1 | Output enable for `dout` |
| dtmf_present | input | 1 | Receiver reports a valid digit |
| dtmf_code | input | 4 | Received digit code |
| fax_raw | input | 1 | Raw fax-tone detection |
| cpt_raw | input | 1 | Raw call-progress detection |
| tx_code | output | 4 | Tone code register |
| cpt_gen_en | output | 1 | Control: call-progress generator on |
| fast_detect | output | 1 | Control: fast digit detection |
| det_out_en | output | 1 | Control: detector outputs enabled |
| dtmf_gen_en | output | 1 | Control: digit generator on |
| fax_out | output | 1 | Masked fax detection |
| cpt_out | output | 1 | Masked call-progress detection |

## Verification
Both bus styles carry the same register traffic: writes to every target, reads of both readable registers, and writes to the read-only addresses. Comparing the two styles shows whether each protocol decodes its own strobe edges and select lines correctly. Detector inputs are raised alone and in pairs. This separates the three set causes of the change flag and shows the call-progress-over-fax priority. The flag is then cleared once by a status read and once by the signal going away, so the two clear paths are shown to work independently. Chip-select-high accesses, reads of the received digit and power-down show what must have no effect: writes that must not land, reads that must not clear the flag, and non-detect reporting that must hold.

// File: rtl/tonereg_pkg.sv
package tonereg_pkg;
  localparam int DW = 4;

  typedef struct packed {
    logic cpt_en;    // bit 3
    logic fast_det;  // bit 2
    logic det_en;    // bit 1
    logic dtmf_en;   // bit 0
  } ctrl_t;

  localparam logic [1:0] A_TXCODE = 2'b00;
  localparam logic [1:0] A_RXDATA = 2'b01;
  localparam logic [1:0] A_CTRL   = 2'b10;
  localparam logic [1:0] A_STATUS = 2'b11;
endpackage

// File: rtl/tonereg_sync.sv
module tonereg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tonereg_bus.sv
module tonereg_bus #(
  parameter int DW = tonereg_pkg::DW,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          intel_mode,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic          wr_stb,
  output logic          wr_ctrl,
  output logic [DW-1:0] wr_data,
  output logic          rd_act,
  output logic          rd_status,
  output logic          rd_end_status
);
  import tonereg_pkg::*;
  localparam int VW = DW + 4;
  localparam logic [VW-1:0] IDLE = {4'b1011, {DW{1'b0}}};

  logic [VW-1:0] raw_v, syn_v;
  logic cs_s, ale_s, rd_s, wr_s;
  logic [DW-1:0] d_s;
  logic rd_p, wr_p, ale_p;
  logic [1:0] addr_q;
  logic mot_sel_q, stat_rd_q;
  logic rd_rise, rd_fall, wr_rise, ale_fall;

  assign raw_v = {cs_n, ale, rd_n, wr_n, din};

  tonereg_sync #(.WIDTH(VW), .STAGES(SYNC), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  assign {cs_s, ale_s, rd_s, wr_s, d_s} = syn_v;
  assign rd_rise  = rd_s & ~rd_p;
  assign rd_fall  = ~rd_s & rd_p;
  assign wr_rise  = wr_s & ~wr_p;
  assign ale_fall = ~ale_s & ale_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p <= 1'b1; wr_p <= 1'b1; ale_p <= 1'b0;
      addr_q <= A_TXCODE; mot_sel_q <= 1'b0; stat_rd_q <= 1'b0;
      wr_stb <= 1'b0; wr_ctrl <= 1'b0; wr_data <= '0;
    end else begin
      rd_p <= rd_s; wr_p <= wr_s; ale_p <= ale_s;
      stat_rd_q <= rd_act & rd_status;
      wr_stb <= 1'b0;
      if (intel_mode) begin
        if (ale_fall) addr_q <= d_s[1:0];
        if (wr_rise && !cs_s && !addr_q[0]) begin
          wr_stb  <= 1'b1;
          wr_ctrl <= (addr_q == A_CTRL);
          wr_data <= d_s;
        end
      end else begin
        if (rd_rise) mot_sel_q <= ale_s;
        if (rd_fall && !cs_s && !wr_s) begin
          wr_stb  <= 1'b1;
          wr_ctrl <= ale_s;
          wr_data <= d_s;
        end
      end
    end
  end

  always_comb begin
    if (intel_mode) begin
      rd_act    = ~rd_s & ~cs_s;
      rd_status = (addr_q == A_STATUS);
    end else begin
      rd_act    = rd_s & ~cs_s & wr_s;
      rd_status = rd_rise ? ale_s : mot_sel_q;
    end
  end

  assign rd_end_status = stat_rd_q & ~(rd_act & rd_status);
endmodule

// File: rtl/tonereg_status.sv
module tonereg_status (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  input  logic det_en,
  input  logic dtmf_present,
  input  logic fax_raw,
  input  logic cpt_raw,
  input  logic rd_clear,
  output logic pres_q,
  output logic fax_q,
  output logic cpt_q,
  output logic flag_q
);
  logic pres_m, fax_m, cpt_m, set_ev, all_gone;

  assign pres_m   = dtmf_present & ~pd;
  assign cpt_m    = cpt_raw & det_en & ~pd;
  assign fax_m    = fax_raw & det_en & ~cpt_raw & ~pd;
  assign set_ev   = (pres_m & ~pres_q) | (fax_m & ~fax_q) | (cpt_m & ~cpt_q);
  assign all_gone = ~pres_m & ~fax_m & ~cpt_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_q <= 1'b0; fax_q <= 1'b0; cpt_q <= 1'b0; flag_q <= 1'b0;
    end else begin
      pres_q <= pres_m;
      fax_q  <= fax_m;
      cpt_q  <= cpt_m;
      if (pd)                       flag_q <= 1'b0;
      else if (set_ev)              flag_q <= 1'b1;
      else if (rd_clear || all_gone) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tonereg_top.sv
module tonereg_top #(
  parameter int DW = tonereg_pkg::DW,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          pwr_down,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          bus_oe,
  input  logic          dtmf_present,
  input  logic [DW-1:0] dtmf_code,
  input  logic          fax_raw,
  input  logic          cpt_raw,
  output logic [DW-1:0] tx_code,
  output logic          cpt_gen_en,
  output logic          fast_detect,
  output logic          det_out_en,
  output logic          dtmf_gen_en,
  output logic          fax_out,
  output logic          cpt_out
);
  import tonereg_pkg::*;

  logic wr_stb, wr_ctrl, rd_act, rd_status, rd_end_status;
  logic [DW-1:0] wr_data, stat_word, rx_word;
  logic pres_q, flag_q;
  ctrl_t ctrl_q;

  tonereg_bus #(.DW(DW), .SYNC(SYNC)) u_bus (
    .clk(clk), .rst(rst), .intel_mode(bus_sel),
    .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .din(din),
    .wr_stb(wr_stb), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .rd_act(rd_act), .rd_status(rd_status), .rd_end_status(rd_end_status)
  );

  tonereg_status u_status (
    .clk(clk), .rst(rst), .pd(pwr_down), .det_en(ctrl_q.det_en),
    .dtmf_present(dtmf_present), .fax_raw(fax_raw), .cpt_raw(cpt_raw),
    .rd_clear(rd_end_status),
    .pres_q(pres_q), .fax_q(fax_out), .cpt_q(cpt_out), .flag_q(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      ctrl_q  <= '0;
      tx_code <= '0;
    end else if (wr_stb) begin
      if (wr_ctrl) ctrl_q  <= ctrl_t'(wr_data[3:0]);
      else         tx_code <= wr_data;
    end
  end

  assign stat_word = DW'({~pres_q, fax_out, cpt_out, flag_q});
  assign rx_word   = pwr_down ? '0 : dtmf_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe <= 1'b0;
      dout   <= '0;
    end else begin
      bus_oe <= rd_act;
      dout   <= rd_act ? (rd_status ? stat_word : rx_word) : '0;
    end
  end

  assign cpt_gen_en  = ctrl_q.cpt_en;
  assign fast_detect = ctrl_q.fast_det;
  assign det_out_en  = ctrl_q.det_en;
  assign dtmf_gen_en = ctrl_q.dtmf_en;
endmodule

// File: rtl/tonereg_checker.sv
module tonereg_checker (
  input logic       clk,
  input logic       rst,
  input logic       pd,
  input logic [3:0] ctrl,
  input logic [3:0] code,
  input logic       fax,
  input logic       cpt,
  input logic       flag,
  input logic       wr_stb
);
  a_r13_pd_clears: assert property (@(posedge clk) disable iff (rst)
    pd |=> (ctrl == 4'd0 && code == 4'd0));

  a_r8_masked_off: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl[1]) |-> (!fax && !cpt));

  a_r9_cpt_over_fax: assert property (@(posedge clk) disable iff (rst)
    cpt |-> !fax);

  a_r10_flag_on_cpt: assert property (@(posedge clk) disable iff (rst)
    $rose(cpt) |-> flag);

  a_r6_ctrl_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_stb) && !$past(pd)) |-> $stable(ctrl));
endmodule

bind tonereg_top tonereg_checker u_chk (
  .clk(clk), .rst(rst), .pd(pwr_down), .ctrl(ctrl_q), .code(tx_code),
  .fax(fax_out), .cpt(cpt_out), .flag(flag_q), .wr_stb(wr_stb)
);

// File: tb/tonereg_top_bench.sv
`timescale 1ns/1ps
module tonereg_top_bench;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b1, pwr_down = 1'b0;
  logic cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] din = 4'h0;
  logic [3:0] dout;
  logic bus_oe;
  logic dtmf_present = 1'b0;
  logic [3:0] dtmf_code = 4'h0;
  logic fax_raw = 1'b0, cpt_raw = 1'b0;
  logic [3:0] tx_code;
  logic cpt_gen_en, fast_detect, det_out_en, dtmf_gen_en, fax_out, cpt_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tonereg_top u_tonereg_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .pwr_down(pwr_down),
    .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .din(din),
    .dout(dout), .bus_oe(bus_oe),
    .dtmf_present(dtmf_present), .dtmf_code(dtmf_code),
    .fax_raw(fax_raw), .cpt_raw(cpt_raw),
    .tx_code(tx_code), .cpt_gen_en(cpt_gen_en), .fast_detect(fast_detect),
    .det_out_en(det_out_en), .dtmf_gen_en(dtmf_gen_en),
    .fax_out(fax_out), .cpt_out(cpt_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] ctrl_pins();
    return {cpt_gen_en, fast_detect, det_out_en, dtmf_gen_en};
  endfunction

  task automatic i_write(input logic [1:0] a, input logic [3:0] d);
    ale = 1'b1; din = {2'b00, a}; wait_cyc(HOLD);
    ale = 1'b0; wait_cyc(HOLD);
    din = d; cs_n = 1'b0; wr_n = 1'b0; wait_cyc(HOLD);
    wr_n = 1'b1; wait_cyc(HOLD);
    cs_n = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic i_read(input logic [1:0] a, output logic [3:0] d, output logic oe);
    ale = 1'b1; din = {2'b00, a}; wait_cyc(HOLD);
    ale = 1'b0; wait_cyc(HOLD);
    cs_n = 1'b0; rd_n = 1'b0; wait_cyc(HOLD);
    d = dout; oe = bus_oe;
    rd_n = 1'b1; wait_cyc(HOLD);
    cs_n = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic m_write(input logic sel, input logic [3:0] d, input logic csv);
    cs_n = csv; wr_n = 1'b0; ale = sel; din = d; wait_cyc(HOLD);
    rd_n = 1'b1; wait_cyc(HOLD);
    rd_n = 1'b0; wait_cyc(HOLD);
    cs_n = 1'b1; wr_n = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic m_read(input logic sel, input logic csv, output logic [3:0] d, output logic oe);
    cs_n = csv; wr_n = 1'b1; ale = sel; wait_cyc(HOLD);
    rd_n = 1'b1; wait_cyc(HOLD);
    d = dout; oe = bus_oe;
    rd_n = 1'b0; wait_cyc(HOLD);
    cs_n = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic t_reset();
    check("reset oe", {7'd0, bus_oe}, 8'd0);
    check("reset R6 ctrl", {4'd0, ctrl_pins()}, 8'd0);
    check("reset R1 code", {4'd0, tx_code}, 8'd0);
    check("reset R8 outs", {6'd0, fax_out, cpt_out}, 8'd0);
  endtask

  task automatic t_intel_writes();
    i_write(2'b00, 4'h9);
    check("R1 code write", {4'd0, tx_code}, 8'h09);
    i_write(2'b10, 4'b1010);
    check("R6 cpt_gen_en bit3", {7'd0, cpt_gen_en}, 8'd1);
    check("R6 fast_detect bit2", {7'd0, fast_detect}, 8'd0);
    check("R6 det_out_en bit1", {7'd0, det_out_en}, 8'd1);
    check("R6 dtmf_gen_en bit0", {7'd0, dtmf_gen_en}, 8'd0);
    i_write(2'b01, 4'h5);
    i_write(2'b11, 4'h5);
    check("R1 read-only addr write ignored code", {4'd0, tx_code}, 8'h09);
    check("R1 read-only addr write ignored ctrl", {4'd0, ctrl_pins()}, 8'h0A);
  endtask

  task automatic t_intel_reads();
    logic [3:0] d; logic oe;
    dtmf_code = 4'h6; dtmf_present = 1'b1; wait_cyc(4);
    i_read(2'b01, d, oe);
    check("R2 oe during read", {7'd0, oe}, 8'd1);
    check("R14 rx digit", {4'd0, d}, 8'h06);
    check("R2 oe after read", {7'd0, bus_oe}, 8'd0);
    i_read(2'b11, d, oe);
    check("R7 R10 status presence set", {4'd0, d}, 8'h01);
    i_read(2'b11, d, oe);
    check("R11 flag cleared by read", {4'd0, d}, 8'h00);
    dtmf_present = 1'b0; wait_cyc(4);
  endtask

  task automatic t_flags();
    logic [3:0] d; logic oe;
    cpt_raw = 1'b1; wait_cyc(4);
    i_read(2'b11, d, oe);
    check("R10 cpt rise status", {4'd0, d}, 8'h0B);
    check("R11 flag held until read ends", {4'd0, d[0]}, 8'h01);
    cpt_raw = 1'b0; wait_cyc(4);
    cpt_raw = 1'b1; wait_cyc(4);
    cpt_raw = 1'b0; wait_cyc(4);
    i_read(2'b11, d, oe);
    check("R12 flag self-clears unread", {4'd0, d}, 8'h08);
    cpt_raw = 1'b1; fax_raw = 1'b1; wait_cyc(4);
    check("R9 fax forced low", {6'd0, fax_out, cpt_out}, 8'h01);
    cpt_raw = 1'b0; wait_cyc(4);
    check("R9 fax after cpt ends", {6'd0, fax_out, cpt_out}, 8'h02);
    i_read(2'b11, d, oe);
    check("R7 R10 fax status", {4'd0, d}, 8'h0D);
    i_write(2'b10, 4'b0000);
    check("R8 fax pin masked", {6'd0, fax_out, cpt_out}, 8'h00);
    i_read(2'b11, d, oe);
    check("R8 status masked", {4'd0, d}, 8'h08);
  endtask

  task automatic t_moto();
    logic [3:0] d; logic oe;
    bus_sel = 1'b0; rd_n = 1'b0; wait_cyc(HOLD);
    m_write(1'b0, 4'hC, 1'b0);
    check("R3 code write", {4'd0, tx_code}, 8'h0C);
    m_write(1'b1, 4'b0110, 1'b0);
    check("R3 ctrl write", {4'd0, ctrl_pins()}, 8'h06);
    dtmf_code = 4'h3; dtmf_present = 1'b1; wait_cyc(4);
    m_read(1'b0, 1'b0, d, oe);
    check("R4 oe during read", {7'd0, oe}, 8'd1);
    check("R4 R14 rx digit", {4'd0, d}, 8'h03);
    m_read(1'b1, 1'b0, d, oe);
    check("R4 R10 status", {4'd0, d}, 8'h05);
    m_read(1'b1, 1'b0, d, oe);
    check("R11 flag cleared moto read", {4'd0, d}, 8'h04);
  endtask

  task automatic t_cs_high();
    logic [3:0] d; logic oe;
    m_write(1'b0, 4'h1, 1'b1);
    check("R5 no write cs high", {4'd0, tx_code}, 8'h0C);
    m_read(1'b0, 1'b1, d, oe);
    check("R5 no drive cs high", {7'd0, oe}, 8'd0);
  endtask

  task automatic t_pd();
    logic [3:0] d; logic oe;
    pwr_down = 1'b1; wait_cyc(4);
    check("R13 ctrl cleared", {4'd0, ctrl_pins()}, 8'h00);
    check("R13 code cleared", {4'd0, tx_code}, 8'h00);
    check("R13 outs low", {6'd0, fax_out, cpt_out}, 8'h00);
    m_read(1'b1, 1'b0, d, oe);
    check("R13 status non-detect", {4'd0, d}, 8'h08);
    m_write(1'b1, 4'hF, 1'b0);
    check("R13 write ignored", {4'd0, ctrl_pins()}, 8'h00);
    m_read(1'b0, 1'b0, d, oe);
    check("R13 rx digit zero", {4'd0, d}, 8'h00);
    pwr_down = 1'b0; wait_cyc(4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_cyc(4);
    t_reset();
    t_intel_writes();
    t_intel_reads();
    t_flags();
    t_moto();
    t_cs_high();
    t_pd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule